// File: doc/BRIEF.md
# UDP/IPv4 Header Stream Builder

This block streams a complete Ethernet, IPv4 and UDP header as a series of 16-bit words taken from a template that software loads through a simple write port. Each template entry holds a 16-bit value and a 4-bit control nibble. The nibble either passes the stored value through or replaces it with a value the block computes as the word goes out: the IPv4 total length, the UDP length, or the IPv4 header checksum. The nibble also marks the word that ends the header.

The payload size in bytes comes from a side input. The block captures it when a start pulse arrives, so the lengths and the checksum stay fixed for the whole header. The block then presents the words from entry 2 upward on a valid/ready stream. Entries 0 and 1 are never emitted. In the usual layout, entries 2 to 8 carry the 14-byte Ethernet header, entries 9 to 18 the 20-byte IPv4 header and entries 19 to 22 the 8-byte UDP header.

Top module: `udp_hdr_stamper`

## Requirements
- R1: While reset is held, and after it is released, `out_valid` is low until a start pulse arrives. Reset clears every template entry to zero.
- R2: A `start` pulse while no header is being sent raises `out_valid` on the next cycle, with the data of entry 2 on `out_data`.
- R3: Words go out in increasing entry order, one per cycle in which `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R4: An entry whose control nibble (bits 19:16) has bit 17 set emits the captured payload length plus 28 instead of its stored data (control value 4'b0010).
- R5: An entry with control bit 16 set emits the captured payload length plus 8 instead of its stored data (control value 4'b0001).
- R6: An entry with control bit 18 set (control value 4'b0100) emits the bitwise inverse of the 16-bit ones'-complement sum, with end-around carry, of the effective values of entries 9 to 13 and 15 to 18. The effective value of an entry is its computed length if bit 17 or 16 is set, and its stored data otherwise.
- R7: An entry with control bit 19 set is the final word. It is emitted with `out_last` high, together with any insertion that bits 18 to 16 select, and `out_valid` falls after it is accepted. If no entry from 2 upward has bit 19 set, the last template entry ends the header.
- R8: A `start` pulse while a header is being sent has no effect on the sequence that is going out.
- R9: Changes on `payload_len` after the start pulse do not affect the lengths or the checksum of the header that is going out.
- R10: A write with `cfg_we` high stores `cfg_wdata` (control in bits 19:16, data in bits 15:0) into entry `cfg_addr`. Later headers emit the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Template write strobe |
| cfg_addr | input | IDX_W | Template entry index |
| cfg_wdata | input | 20 | Control nibble and data for the entry |
| payload_len | input | 16 | Payload size in bytes, captured at start |
| start | input | 1 | Begin sending a header |
| out_valid | output | 1 | Header word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 16 | Header word |
| out_last | output | 1 | Word is the final one of the header |

## Verification
The bench targets the checksum. A carry left unfolded, or a checksum summed from the stored data of the length entry instead of the computed length, gives a wrong checksum word. Backpressure on irregular cycles shows whether a word is skipped or repeated when `out_ready` is low. The bench changes `payload_len` and pulses `start` while a header is going out, which catches a design that does not capture the length at start or that restarts its sequence. Removing the final-word mark shows whether the sequencer stops at the top of the template or runs past it.

// File: rtl/udp_hdr_stamper.sv
module udp_hdr_stamper #(
  parameter int NUM_ENTRIES = 32,
  parameter int IDX_W = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_addr,
  input  logic [19:0]      cfg_wdata,
  input  logic [15:0]      payload_len,
  input  logic             start,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [15:0]      out_data,
  output logic             out_last
);
  localparam int FIRST_IDX = 2;
  localparam int IP_LO     = 9;
  localparam int IP_HI     = 18;
  localparam int CHK_SLOT  = 14;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_ENTRIES - 1);

  logic [19:0]      tmpl [NUM_ENTRIES];
  logic [IDX_W-1:0] idx;
  logic             active;
  logic [15:0]      len_q;

  wire [15:0] ip_len  = len_q + 16'd28;
  wire [15:0] udp_len = len_q + 16'd8;

  function automatic logic [15:0] eff(input logic [19:0] e, input logic [15:0] il, input logic [15:0] ul);
    if (e[17])      return il;
    else if (e[16]) return ul;
    else            return e[15:0];
  endfunction

  logic [19:0] acc;
  logic [16:0] fold1;
  logic [15:0] fold2;
  logic [15:0] chk;

  always_comb begin
    acc = '0;
    for (int i = IP_LO; i <= IP_HI; i++)
      if (i != CHK_SLOT) acc = acc + {4'd0, eff(tmpl[i], ip_len, udp_len)};
  end

  assign fold1 = {1'b0, acc[15:0]} + {13'd0, acc[19:16]};
  assign fold2 = fold1[15:0] + {15'd0, fold1[16]};
  assign chk   = ~fold2;

  wire [19:0] cur = tmpl[idx];
  wire        fin = cur[19] || (idx == TOP_IDX);

  assign out_valid = active;
  assign out_last  = active && fin;
  assign out_data  = cur[18] ? chk : eff(cur, ip_len, udp_len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tmpl[i] <= '0;
    end else if (cfg_we) begin
      tmpl[cfg_addr] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= IDX_W'(FIRST_IDX);
      len_q  <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        idx    <= IDX_W'(FIRST_IDX);
        len_q  <= payload_len;
      end
    end else if (out_ready) begin
      if (fin) active <= 1'b0;
      else     idx    <= idx + 1'b1;
    end
  end
endmodule

module udp_hdr_stamper_chk #(
  parameter int IDX_W = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic        start,
  input logic        out_valid,
  input logic        out_ready,
  input logic [15:0] out_data,
  input logic        out_last
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
    start && !out_valid |=> out_valid);

  a_r3_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !cfg_we |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r7_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  a_r8_no_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !(out_ready && out_last) |=> out_valid);
endmodule

bind udp_hdr_stamper udp_hdr_stamper_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .start(start),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/udp_hdr_stamper_test.sv
module udp_hdr_stamper_test;
  localparam int N = 32;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0, cfg_we = 0, start = 0, out_ready = 0;
  logic [IW-1:0] cfg_addr = '0;
  logic [19:0] cfg_wdata = '0;
  logic [15:0] payload_len = '0;
  logic out_valid, out_last;
  logic [15:0] out_data;

  int total = 0, bad = 0;
  bit done = 0;
  logic [19:0] shadow [N];

  always #5 clk = ~clk;

  udp_hdr_stamper #(.NUM_ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .payload_len(payload_len), .start(start), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [3:0] c, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = IW'(a); cfg_wdata = {c, d};
    @(negedge clk);
    cfg_we = 0;
    shadow[a] = {c, d};
  endtask

  function automatic logic [15:0] model_eff(input int i, input logic [15:0] len);
    if (shadow[i][17]) return len + 16'd28;
    if (shadow[i][16]) return len + 16'd8;
    return shadow[i][15:0];
  endfunction

  function automatic logic [15:0] model_chk(input logic [15:0] len);
    logic [31:0] s = 0;
    for (int i = 9; i <= 18; i++) if (i != 14) s += model_eff(i, len);
    while (s[31:16] != 0) s = s[15:0] + s[31:16];
    return ~s[15:0];
  endfunction

  function automatic logic [15:0] model_word(input int i, input logic [15:0] len);
    if (shadow[i][18]) return model_chk(len);
    return model_eff(i, len);
  endfunction

  // bp: stall pattern on; poke: disturb payload_len and start mid-header
  task automatic run_header(input string req, input logic [15:0] len, input bit bp, input bit poke);
    int i = 2, cyc = 0, words = 0;
    bit fin = 0;
    @(negedge clk);
    payload_len = len; start = 1;
    @(negedge clk);
    start = 0;
    check({req, " R2 valid after start"}, out_valid, 1);
    while (!fin && cyc < 200) begin
      out_ready = !bp || (cyc % 3 != 1);
      if (poke) begin payload_len = len ^ 16'h5a5a; start = (cyc == 2); end
      if (out_valid && out_ready) begin
        logic exp_last;
        exp_last = shadow[i][19] || (i == N-1);
        check($sformatf("%s R3 word entry %0d", req, i), out_data, model_word(i, len));
        check($sformatf("%s R7 last flag entry %0d", req, i), out_last, exp_last);
        words++;
        fin = exp_last;
        i++;
      end else if (!out_valid) begin
        check({req, " R8 valid dropped early"}, out_valid, 1);
        fin = 1;
      end
      @(negedge clk);
      cyc++;
    end
    start = 0; out_ready = 0;
    check({req, " R7 valid low after last"}, out_valid, 0);
    repeat (3) @(negedge clk);
    check({req, " R7 stays idle"}, out_valid, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 valid during reset", out_valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R1 valid after reset", out_valid, 0);
    for (int k = 0; k < N; k++) shadow[k] = '0;
  endtask

  task automatic t_load;
    for (int k = 2; k <= 8; k++) wr(k, 4'h0, 16'h1100 + 16'(k * 16'h0101));
    wr(9,  4'h0, 16'h4500);
    wr(10, 4'b0010, 16'hdead);
    wr(11, 4'h0, 16'h1c46);
    wr(12, 4'h0, 16'h4000);
    wr(13, 4'h0, 16'h4011);
    wr(14, 4'b0100, 16'hbeef);
    wr(15, 4'h0, 16'hac10);
    wr(16, 4'h0, 16'h0a63);
    wr(17, 4'h0, 16'hac10);
    wr(18, 4'h0, 16'h0a0c);
    wr(19, 4'h0, 16'h3039);
    wr(20, 4'h0, 16'hd431);
    wr(21, 4'b0001, 16'hffff);
    wr(22, 4'b1000, 16'h0000);
  endtask

  task automatic t_basic;
    run_header("R4 R5 R6 R10 basic len=100", 16'd100, 0, 0);
    run_header("R6 carry len=0xfff0", 16'hfff0, 0, 0);
  endtask

  task automatic t_backpressure;
    run_header("R3 stalls", 16'd512, 1, 0);
  endtask

  task automatic t_disturb;
    run_header("R8 R9 midheader", 16'd64, 1, 1);
  endtask

  task automatic t_short_last;
    wr(4, 4'b1001, 16'h7777);
    run_header("R7 R5 last with insert", 16'd20, 0, 0);
    wr(4, 4'h0, 16'h1504);
  endtask

  task automatic t_no_mark;
    wr(22, 4'h0, 16'h0000);
    run_header("R7 runs to top", 16'd33, 0, 0);
    wr(22, 4'b1000, 16'h0000);
  endtask

  initial begin
    t_reset();
    t_load();
    t_basic();
    t_backpressure();
    t_disturb();
    t_short_last();
    t_no_mark();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule